// File: doc/BRIEF.md
# Dual-Core Reservation Monitor for Load-Link / Store-Conditional

This block lets two cores that share one word-addressed memory build atomic read-modify-write sequences. A core issues a load-link: the block returns the current word and notes a reservation for that core. Later the same core issues a store-conditional. The new value reaches memory only if nothing has written that word since the load-link. The core receives 1 on success and 0 on failure, and software loops back to the load-link when it sees 0.

Each core has one reservation, made of a valid flag and a word index. The reservation is lost in these cases:
- any store by either core to the reserved word, including a plain store of zero that releases a lock;
- a successful store-conditional to that word;
- the core's own store-conditional, whether or not it commits;
- a trap-entry pulse for that core.

Memory is held inside the block. Requests come in over one port per core, and each core gets a registered response port.

Top module: `llsc_monitor`

## Requirements
- R1: A load-link (op code 2'b01) returns, one clock later on the core's response port, the word held before that cycle's writes. The response valid flag is high for exactly that cycle.
- R2: A store-conditional (op code 2'b11) writes memory and returns 1 only if its core holds a valid reservation on the same word index and nothing breaks that reservation in the same cycle. Otherwise it returns 0 and memory stays unchanged. The response data is always 0 or 1.
- R3: A committed write to a reserved word clears that reservation. This covers plain stores (op code 2'b10) and successful store-conditionals from either core, including a store of zero.
- R4: A store-conditional clears its own core's reservation whether it succeeds or fails.
- R5: A new load-link replaces the core's previous reservation. A store-conditional to the old word then fails.
- R6: When both cores issue a store-conditional to the same word in the same cycle, and both are otherwise eligible, core 0 commits and core 1 returns 0.
- R7: A plain store from one core and a store-conditional from the other, both to the same word in the same cycle: the store commits and the store-conditional returns 0.
- R8: A trap-entry pulse clears that core's reservation, even when a load-link is issued in the same cycle. A store-conditional in the same cycle as the trap fails.
- R9: A load-link and a write from the other core to the same word in the same cycle: the load-link returns the old word and leaves no reservation.
- R10: Two plain stores to the same word in the same cycle leave core 0's data in memory.
- R11: Reset clears all reservations and both response valid flags.
- R12: Idle (op code 2'b00) and plain stores raise no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_op | input | 2 | Core 0 operation: 00 idle, 01 load-link, 10 store, 11 store-conditional |
| c0_addr | input | IDX_W | Core 0 word index |
| c0_wdata | input | DW | Core 0 store data |
| c0_trap | input | 1 | Core 0 trap entry, clears its reservation |
| c1_op | input | 2 | Core 1 operation, same coding |
| c1_addr | input | IDX_W | Core 1 word index |
| c1_wdata | input | DW | Core 1 store data |
| c1_trap | input | 1 | Core 1 trap entry |
| c0_rsp_valid | output | 1 | Core 0 response present |
| c0_rsp_data | output | DW | Core 0 load-link word or store-conditional flag |
| c1_rsp_valid | output | 1 | Core 1 response present |
| c1_rsp_data | output | DW | Core 1 load-link word or store-conditional flag |

## Verification
Several functions can land on the same word in the same cycle, and these collisions are the focus. The first pair is a store-conditional from each core. The second is a plain store from one core against a store-conditional from the other. The third is a load-link racing a committed write. The stimulus table places these requests in a single cycle on a shared index. Each case is judged by the flags returned on the next cycle and by a follow-up load-link that reads back which data won.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    localparam int NCORE = 2;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_LL   = 2'b01,
        OP_ST   = 2'b10,
        OP_SC   = 2'b11
    } llsc_op_e;

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter
    import llsc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  llsc_op_e [NCORE-1:0]            op,
    input  logic     [NCORE-1:0][IDX_W-1:0] addr,
    input  logic     [NCORE-1:0]            trap,
    input  logic     [NCORE-1:0]            resv_vld,
    input  logic     [NCORE-1:0][IDX_W-1:0] resv_idx,
    output logic     [NCORE-1:0]            sc_ok,
    output logic     [NCORE-1:0]            wr_en
);

    logic [NCORE-1:0] is_st;
    logic [NCORE-1:0] sc_elig;
    logic [NCORE-1:0] st_clash;
    logic             same_idx;

    always_comb begin
        same_idx = (addr[0] == addr[1]);
        for (int c = 0; c < NCORE; c++) begin
            is_st[c]   = (op[c] == OP_ST);
            sc_elig[c] = (op[c] == OP_SC) && resv_vld[c] &&
                         (resv_idx[c] == addr[c]) && !trap[c];
        end
        // a plain store from the other core to the same word defeats an SC
        st_clash[0] = is_st[1] && same_idx;
        st_clash[1] = is_st[0] && same_idx;

        sc_ok[0] = sc_elig[0] && !st_clash[0];
        // core 0 has priority on a simultaneous SC to the same word
        sc_ok[1] = sc_elig[1] && !st_clash[1] && !(sc_ok[0] && same_idx);

        wr_en = is_st | sc_ok;
    end

endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem
    import llsc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic                            clk,
    input  logic [NCORE-1:0][IDX_W-1:0]     idx,
    input  logic [NCORE-1:0]                wr_en,
    input  logic [NCORE-1:0][DW-1:0]        wr_data,
    output logic [NCORE-1:0][DW-1:0]        rd_data
);

    typedef logic [DW-1:0] word_t;

    word_t mem_q [DEPTH];
    word_t mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        // apply core 1 first so core 0 overrides on a shared index
        for (int c = NCORE - 1; c >= 0; c--) begin
            if (wr_en[c]) begin
                mem_d[idx[c]] = wr_data[c];
            end
        end
        for (int c = 0; c < NCORE; c++) begin
            rd_data[c] = mem_q[idx[c]];
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot
    import llsc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  llsc_op_e                    op,
    input  logic [IDX_W-1:0]            addr,
    input  logic                        trap,
    input  logic [NCORE-1:0]            wr_en,
    input  logic [NCORE-1:0][IDX_W-1:0] wr_idx,
    output logic                        vld,
    output logic [IDX_W-1:0]            idx
);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  hit_new;
    logic  hit_old;

    always_comb begin
        hit_new = 1'b0;
        hit_old = 1'b0;
        for (int c = 0; c < NCORE; c++) begin
            if (wr_en[c] && (wr_idx[c] == addr))       hit_new = 1'b1;
            if (wr_en[c] && (wr_idx[c] == slot_q.idx)) hit_old = 1'b1;
        end

        slot_d = slot_q;
        if (trap) begin
            slot_d.vld = 1'b0;
        end else if (op == OP_LL) begin
            slot_d.vld = !hit_new;
            slot_d.idx = addr;
        end else if (op == OP_SC) begin
            slot_d.vld = 1'b0;
        end else if (slot_q.vld && hit_old) begin
            slot_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign vld = slot_q.vld;
    assign idx = slot_q.idx;

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter  int DW    = 32,
    parameter  int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       c0_op,
    input  logic [IDX_W-1:0] c0_addr,
    input  logic [DW-1:0]    c0_wdata,
    input  logic             c0_trap,
    input  logic [1:0]       c1_op,
    input  logic [IDX_W-1:0] c1_addr,
    input  logic [DW-1:0]    c1_wdata,
    input  logic             c1_trap,
    output logic             c0_rsp_valid,
    output logic [DW-1:0]    c0_rsp_data,
    output logic             c1_rsp_valid,
    output logic [DW-1:0]    c1_rsp_data
);

    llsc_op_e [NCORE-1:0]            op_w;
    logic     [NCORE-1:0][IDX_W-1:0] addr_w;
    logic     [NCORE-1:0][DW-1:0]    wdata_w;
    logic     [NCORE-1:0]            trap_w;
    logic     [NCORE-1:0]            resv_vld;
    logic     [NCORE-1:0][IDX_W-1:0] resv_idx;
    logic     [NCORE-1:0]            sc_ok;
    logic     [NCORE-1:0]            wr_en;
    logic     [NCORE-1:0][DW-1:0]    rd_data;

    assign op_w[0]    = llsc_op_e'(c0_op);
    assign op_w[1]    = llsc_op_e'(c1_op);
    assign addr_w[0]  = c0_addr;
    assign addr_w[1]  = c1_addr;
    assign wdata_w[0] = c0_wdata;
    assign wdata_w[1] = c1_wdata;
    assign trap_w[0]  = c0_trap;
    assign trap_w[1]  = c1_trap;

    llsc_arbiter #(.IDX_W(IDX_W)) u_arb (
        .op       (op_w),
        .addr     (addr_w),
        .trap     (trap_w),
        .resv_vld (resv_vld),
        .resv_idx (resv_idx),
        .sc_ok    (sc_ok),
        .wr_en    (wr_en)
    );

    llsc_word_mem #(.DW(DW), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk     (clk),
        .idx     (addr_w),
        .wr_en   (wr_en),
        .wr_data (wdata_w),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NCORE; g++) begin : g_slot
        llsc_resv_slot #(.IDX_W(IDX_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (op_w[g]),
            .addr   (addr_w[g]),
            .trap   (trap_w[g]),
            .wr_en  (wr_en),
            .wr_idx (addr_w),
            .vld    (resv_vld[g]),
            .idx    (resv_idx[g])
        );
    end

    typedef struct packed {
        logic [NCORE-1:0]         vld;
        logic [NCORE-1:0][DW-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = rsp_q;
        for (int c = 0; c < NCORE; c++) begin
            rsp_d.vld[c] = (op_w[c] == OP_LL) || (op_w[c] == OP_SC);
            if (op_w[c] == OP_LL) begin
                rsp_d.data[c] = rd_data[c];
            end else if (op_w[c] == OP_SC) begin
                rsp_d.data[c] = {{(DW-1){1'b0}}, sc_ok[c]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign c0_rsp_valid = rsp_q.vld[0];
    assign c1_rsp_valid = rsp_q.vld[1];
    assign c0_rsp_data  = rsp_q.data[0];
    assign c1_rsp_data  = rsp_q.data[1];

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  c0_op,
    input logic [1:0]                  c1_op,
    input logic [IDX_W-1:0]            c0_addr,
    input logic [IDX_W-1:0]            c1_addr,
    input logic                        c0_trap,
    input logic                        c1_trap,
    input logic [NCORE-1:0]            resv_vld,
    input logic [NCORE-1:0][IDX_W-1:0] resv_idx,
    input logic [NCORE-1:0]            wr_en,
    input logic                        c0_rsp_valid,
    input logic [DW-1:0]               c0_rsp_data,
    input logic                        c1_rsp_valid,
    input logic [DW-1:0]               c1_rsp_data
);

    assert_ll_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_op == OP_LL) |=> c0_rsp_valid);

    assert_sc_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_op == OP_SC) |=> (c1_rsp_valid && (c1_rsp_data[DW-1:1] == '0)));

    assert_sc_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((c0_op == OP_SC) && !(resv_vld[0] && (resv_idx[0] == c0_addr))) |-> !wr_en[0]);

    assert_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_vld[0] && wr_en[1] && (c1_addr == resv_idx[0]) && (c0_op != OP_LL))
        |=> !resv_vld[0]);

    assert_sc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_op == OP_SC) |=> !resv_vld[1]);

    assert_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((c0_op == OP_SC) && (c1_op == OP_SC) && (c0_addr == c1_addr) && wr_en[0])
        |-> !wr_en[1]);

    assert_st_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((c0_op == OP_ST) && (c1_op == OP_SC) && (c0_addr == c1_addr))
        |=> (c1_rsp_data == '0));

    assert_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c0_trap |=> !resv_vld[0]);

    assert_trap1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c1_trap |=> !resv_vld[1]);

    assert_no_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((c0_op == OP_IDLE) || (c0_op == OP_ST)) |=> !c0_rsp_valid);

endmodule

bind llsc_monitor llsc_monitor_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .c0_op        (c0_op),
    .c1_op        (c1_op),
    .c0_addr      (c0_addr),
    .c1_addr      (c1_addr),
    .c0_trap      (c0_trap),
    .c1_trap      (c1_trap),
    .resv_vld     (resv_vld),
    .resv_idx     (resv_idx),
    .wr_en        (wr_en),
    .c0_rsp_valid (c0_rsp_valid),
    .c0_rsp_data  (c0_rsp_data),
    .c1_rsp_valid (c1_rsp_valid),
    .c1_rsp_data  (c1_rsp_data)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;

    localparam int DW    = 32;
    localparam int DEPTH = 16;
    localparam int IW    = 4;
    localparam logic [1:0] I = 2'b00, L = 2'b01, S = 2'b10, C = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    c0_op = I, c1_op = I;
    logic [IW-1:0] c0_addr = '0, c1_addr = '0;
    logic [DW-1:0] c0_wdata = '0, c1_wdata = '0;
    logic          c0_trap = 1'b0, c1_trap = 1'b0;
    logic          c0_rsp_valid, c1_rsp_valid;
    logic [DW-1:0] c0_rsp_data, c1_rsp_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    llsc_monitor #(.DW(DW), .DEPTH(DEPTH)) i_llsc_monitor (
        .clk(clk), .rst_n(rst_n),
        .c0_op(c0_op), .c0_addr(c0_addr), .c0_wdata(c0_wdata), .c0_trap(c0_trap),
        .c1_op(c1_op), .c1_addr(c1_addr), .c1_wdata(c1_wdata), .c1_trap(c1_trap),
        .c0_rsp_valid(c0_rsp_valid), .c0_rsp_data(c0_rsp_data),
        .c1_rsp_valid(c1_rsp_valid), .c1_rsp_data(c1_rsp_data)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  op0; logic [3:0] a0; logic [31:0] w0; logic t0;
        logic [1:0]  op1; logic [3:0] a1; logic [31:0] w1; logic t1;
        logic        ev0; logic [31:0] ed0;
        logic        ev1; logic [31:0] ed1;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{4'd12, S,4'd3,32'h11,1'b0, S,4'd5,32'h22,1'b0, 1'b0,32'h0, 1'b0,32'h0},   // R12 stores silent
        '{4'd1,  L,4'd3,32'h0,1'b0,  L,4'd5,32'h0,1'b0,  1'b1,32'h11,1'b1,32'h22},  // R1
        '{4'd2,  C,4'd3,32'h33,1'b0, I,4'd0,32'h0,1'b0,  1'b1,32'h1, 1'b0,32'h0},   // R2 success
        '{4'd2,  L,4'd3,32'h0,1'b0,  I,4'd0,32'h0,1'b0,  1'b1,32'h33,1'b0,32'h0},   // R2 committed
        '{4'd2,  I,4'd0,32'h0,1'b0,  C,4'd5,32'h44,1'b0, 1'b0,32'h0, 1'b1,32'h1},   // R2 core 1
        '{4'd1,  I,4'd0,32'h0,1'b0,  L,4'd3,32'h0,1'b0,  1'b0,32'h0, 1'b1,32'h33},  // R1
        '{4'd6,  C,4'd3,32'h55,1'b0, C,4'd3,32'h66,1'b0, 1'b1,32'h1, 1'b1,32'h0},   // R6 tie
        '{4'd6,  L,4'd3,32'h0,1'b0,  L,4'd5,32'h0,1'b0,  1'b1,32'h55,1'b1,32'h44},  // R6 core 0 data
        '{4'd3,  I,4'd0,32'h0,1'b0,  S,4'd3,32'h0,1'b0,  1'b0,32'h0, 1'b0,32'h0},   // R3 release store
        '{4'd3,  C,4'd3,32'h77,1'b0, I,4'd0,32'h0,1'b0,  1'b1,32'h0, 1'b0,32'h0},   // R3 broken
        '{4'd2,  L,4'd3,32'h0,1'b0,  I,4'd0,32'h0,1'b0,  1'b1,32'h0, 1'b0,32'h0},   // R2 no write
        '{4'd8,  I,4'd0,32'h0,1'b1,  I,4'd0,32'h0,1'b0,  1'b0,32'h0, 1'b0,32'h0},   // R8 trap
        '{4'd8,  C,4'd3,32'h88,1'b0, I,4'd0,32'h0,1'b0,  1'b1,32'h0, 1'b0,32'h0},   // R8 SC after trap
        '{4'd3,  L,4'd3,32'h0,1'b0,  C,4'd5,32'h99,1'b0, 1'b1,32'h0, 1'b1,32'h1},   // R3 other word untouched
        '{4'd2,  C,4'd6,32'hAA,1'b0, L,4'd5,32'h0,1'b0,  1'b1,32'h0, 1'b1,32'h99},  // R2 index mismatch
        '{4'd4,  C,4'd3,32'hBB,1'b0, I,4'd0,32'h0,1'b0,  1'b1,32'h0, 1'b0,32'h0},   // R4 failed SC cleared
        '{4'd1,  L,4'd3,32'h0,1'b0,  L,4'd3,32'h0,1'b0,  1'b1,32'h0, 1'b1,32'h0},   // R1 both read
        '{4'd7,  S,4'd3,32'h12,1'b0, C,4'd3,32'h34,1'b0, 1'b0,32'h0, 1'b1,32'h0},   // R7 clash
        '{4'd4,  L,4'd3,32'h0,1'b0,  C,4'd5,32'h0,1'b0,  1'b1,32'h12,1'b1,32'h0},   // R7 data, R4
        '{4'd9,  C,4'd3,32'h56,1'b0, L,4'd3,32'h0,1'b0,  1'b1,32'h1, 1'b1,32'h12},  // R9 old value
        '{4'd9,  L,4'd3,32'h0,1'b0,  C,4'd3,32'h78,1'b0, 1'b1,32'h56,1'b1,32'h0},   // R9 no reservation
        '{4'd8,  L,4'd3,32'h0,1'b1,  I,4'd0,32'h0,1'b0,  1'b1,32'h56,1'b0,32'h0},   // R8 LL with trap
        '{4'd8,  C,4'd3,32'h9A,1'b0, I,4'd0,32'h0,1'b0,  1'b1,32'h0, 1'b0,32'h0},   // R8 fails
        '{4'd10, S,4'd4,32'hA1,1'b0, S,4'd4,32'hB2,1'b0, 1'b0,32'h0, 1'b0,32'h0},   // R10 double store
        '{4'd10, L,4'd4,32'h0,1'b0,  I,4'd0,32'h0,1'b0,  1'b1,32'hA1,1'b0,32'h0},   // R10 core 0 wins
        '{4'd5,  I,4'd0,32'h0,1'b0,  L,4'd5,32'h0,1'b0,  1'b0,32'h0, 1'b1,32'h99},  // R5
        '{4'd5,  I,4'd0,32'h0,1'b0,  L,4'd4,32'h0,1'b0,  1'b0,32'h0, 1'b1,32'hA1},  // R5 replace
        '{4'd5,  I,4'd0,32'h0,1'b0,  C,4'd5,32'hCC,1'b0, 1'b0,32'h0, 1'b1,32'h0},   // R5 old word fails
        '{4'd5,  I,4'd0,32'h0,1'b0,  L,4'd5,32'h0,1'b0,  1'b0,32'h0, 1'b1,32'h99}   // R5 no write
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        c0_op = v.op0; c0_addr = v.a0; c0_wdata = v.w0; c0_trap = v.t0;
        c1_op = v.op1; c1_addr = v.a1; c1_wdata = v.w1; c1_trap = v.t1;
    endtask

    task automatic idle();
        c0_op = I; c1_op = I; c0_trap = 1'b0; c1_trap = 1'b0;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: outputs quiet out of reset
        check("R11 c0 valid after reset", {31'b0, c0_rsp_valid}, 32'h0);
        check("R11 c1 valid after reset", {31'b0, c1_rsp_valid}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vec %0d c0 valid", VEC[i].rq, i), {31'b0, c0_rsp_valid}, {31'b0, VEC[i].ev0});
            check($sformatf("R%0d vec %0d c1 valid", VEC[i].rq, i), {31'b0, c1_rsp_valid}, {31'b0, VEC[i].ev1});
            if (VEC[i].ev0) check($sformatf("R%0d vec %0d c0 data", VEC[i].rq, i), c0_rsp_data, VEC[i].ed0);
            if (VEC[i].ev1) check($sformatf("R%0d vec %0d c1 data", VEC[i].rq, i), c1_rsp_data, VEC[i].ed1);
        end

        // R11: reset drops a live reservation
        c0_op = L; c0_addr = 4'd4; c1_op = I;
        @(posedge clk); @(negedge clk);
        check("R11 LL before reset", c0_rsp_data, 32'hA1);
        idle();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R11 valid during reset", {31'b0, c0_rsp_valid}, 32'h0);
        rst_n = 1'b1;
        c0_op = C; c0_addr = 4'd4; c0_wdata = 32'hFF;
        @(posedge clk); @(negedge clk);
        check("R11 SC after reset", c0_rsp_data, 32'h0);
        c0_op = L;
        @(posedge clk); @(negedge clk);
        check("R11 word unchanged", c0_rsp_data, 32'hA1);
        idle();
        @(posedge clk); @(negedge clk);
        check("R12 idle no response", {31'b0, c0_rsp_valid}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule